// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes from a host onto a single asynchronous serial line. A host write puts a character into a holding buffer. The buffer passes the character to a shift register as soon as the shift register has no frame in progress. While one frame is on the line, the buffer can already hold the next character, so a steady host keeps the line busy without gaps. Each frame carries a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The line idles high.

The bit time comes from a built-in rate divider. Its count source is either the system clock or the system clock divided by 4. The divider divides that source by n+1, where n is a host value, and a further divide-by-16 stage then yields one bit period. The block has two status flags. `buf_empty` shows that the holding buffer may be written. `shift_done` shows that the last stop bit has left the line. A select input picks which of the two flags raises the one-cycle interrupt pulse.

The shifter is a state machine with the states TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP1 and TX_STOP2. Its transitions are:

- TX_IDLE to TX_START: the buffer holds a character (this is the load).
- TX_START to TX_DATA: a bit period ends.
- TX_DATA to TX_PARITY: the last data bit ends and parity is enabled.
- TX_DATA to TX_STOP1: the last data bit ends and parity is disabled.
- TX_PARITY to TX_STOP1: a bit period ends.
- TX_STOP1 to TX_STOP2: a bit period ends in two-stop mode.
- Last stop bit to TX_START: the last stop bit (TX_STOP1, or TX_STOP2 in two-stop mode) ends and the buffer is full. This is a back-to-back load.
- Last stop bit to TX_IDLE: the last stop bit ends and the buffer is empty.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, `txd`=1, `buf_empty`=1, `shift_done`=1 and `irq`=0.
- R2: Every bit lasts exactly (`brg_div4` ? 4 : 1) × (`brg_n`+1) × 16 clock cycles.
- R3: A frame is one low start bit, then the data bits least significant bit first (8 bits when `char8`=1, bits 6..0 when `char8`=0), then a parity bit if `par_en`=1, then high stop bits (two when `stop2`=1, one otherwise).
- R4: When `par_odd`=0, the parity bit makes the count of ones over the data bits plus the parity bit even. When `par_odd`=1, it makes that count odd.
- R5: A write (`wr_en`=1 at a clock edge) clears `buf_empty` from the next cycle on. With the shifter idle, the transfer happens at the following edge: `buf_empty` returns to 1 and the start bit begins on that same edge.
- R6: `shift_done` drops on the edge that loads a frame. It rises on the edge that ends the last stop bit, which is the second stop bit in two-stop mode, provided no further character is waiting.
- R7: If the buffer is full when the last stop bit ends, the next start bit begins on that same edge and `shift_done` stays 0.
- R8: A write on the same edge as a buffer-to-shifter transfer sends the old character first and keeps the new one in the buffer, so `buf_empty` stays 0.
- R9: `irq` is a one-cycle pulse in the cycle after the selected flag rises: `buf_empty` when `irq_sel`=0, `shift_done` when `irq_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the holding buffer |
| wr_data | input | DATA_W | Character to transmit |
| char8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| irq_sel | input | 1 | Interrupt cause: 0 buffer empty, 1 shift done |
| brg_div4 | input | 1 | Rate divider count source: 1 clock/4, 0 clock |
| brg_n | input | DIV_W | Rate divider value n (ratio 1/(n+1)) |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer may be written |
| shift_done | output | 1 | No frame on the line |
| irq | output | 1 | Transmit interrupt pulse |

## Verification
A host write and the transfer from the buffer into the shift register can fall on the same clock edge. The bench provokes this twice. First it writes a character into an idle block and raises the next write strobe so that it is sampled on the transfer edge. Later it refills the buffer so that the refill lands on the edge that ends a stop bit. In both cases the bench judges the result from the line and the flags. The first character must go out first. `buf_empty` must stay low through that edge, with no interrupt pulse in buffer-empty mode. The second character must follow with no idle bit between the frames, and only its transfer may raise `buf_empty`.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP1,
        TX_STOP2
    } tx_state_e;

    typedef struct packed {
        logic char8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } tx_fmt_t;

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W      = 8,
    parameter int PRESCALE   = 4,
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div4,
    input  logic [DIV_W-1:0] div_n,
    output logic             bit_tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int SUB_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [SUB_W-1:0] sub_cnt;
    logic             pre_tick;
    logic             div_tick;

    // Count source: clock or clock / PRESCALE
    assign pre_tick = !div4 || (pre_cnt == PRE_LAST);
    // Divide by n+1
    assign div_tick = pre_tick && (div_cnt >= div_n);
    // Divide by OVERSAMPLE to form one bit time
    assign bit_tick = div_tick && (sub_cnt == SUB_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            sub_cnt <= '0;
        end else begin
            if (pre_tick) begin
                pre_cnt <= '0;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
            if (pre_tick) begin
                div_cnt <= div_tick ? '0 : div_cnt + 1'b1;
            end
            if (div_tick) begin
                sub_cnt <= (sub_cnt == SUB_LAST) ? '0 : sub_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (wr_en) begin
                // A write on the transfer edge refills the buffer.
                data <= wr_data;
                full <= 1'b1;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  tx_fmt_t           fmt,
    output logic              take,
    output logic              run,
    output logic              txd,
    output logic              shift_done
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);
    localparam logic [DATA_W-1:0] MASK_SHORT = {1'b0, {(DATA_W-1){1'b1}}};

    tx_state_e         state, state_nx;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  idx_q;
    logic              char8_q;
    logic              par_en_q;
    logic              stop2_q;
    logic              par_q;
    logic              done_q;
    logic              last_bit;
    logic              last_stop;
    logic [DATA_W-1:0] load_mask;

    assign last_bit  = (idx_q == (char8_q ? LAST_LONG : LAST_SHORT));
    assign last_stop = (state == TX_STOP2) || ((state == TX_STOP1) && !stop2_q);
    assign take      = hold_full && ((state == TX_IDLE) || (bit_tick && last_stop));
    assign run       = (state != TX_IDLE);
    assign load_mask = fmt.char8 ? '1 : MASK_SHORT;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:   if (hold_full) state_nx = TX_START;
            TX_START:  if (bit_tick) state_nx = TX_DATA;
            TX_DATA:   if (bit_tick && last_bit) state_nx = par_en_q ? TX_PARITY : TX_STOP1;
            TX_PARITY: if (bit_tick) state_nx = TX_STOP1;
            TX_STOP1:  if (bit_tick) state_nx = stop2_q ? TX_STOP2
                                              : (hold_full ? TX_START : TX_IDLE);
            TX_STOP2:  if (bit_tick) state_nx = hold_full ? TX_START : TX_IDLE;
            default:   state_nx = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Frame datapath: shift register, bit index, latched format, flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            idx_q    <= '0;
            char8_q  <= 1'b1;
            par_en_q <= 1'b0;
            stop2_q  <= 1'b0;
            par_q    <= 1'b0;
            done_q   <= 1'b1;
        end else if (take) begin
            sh_q     <= hold_data;
            idx_q    <= '0;
            char8_q  <= fmt.char8;
            par_en_q <= fmt.par_en;
            stop2_q  <= fmt.stop2;
            par_q    <= (^(hold_data & load_mask)) ^ fmt.par_odd;
            done_q   <= 1'b0;
        end else if (bit_tick) begin
            if (state == TX_DATA) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + 1'b1;
            end
            if (last_stop) begin
                done_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        txd = 1'b1;
        unique case (state)
            TX_IDLE:   txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = sh_q[0];
            TX_PARITY: txd = par_q;
            TX_STOP1:  txd = 1'b1;
            TX_STOP2:  txd = 1'b1;
            default:   txd = 1'b1;
        endcase
        shift_done = done_q;
    end

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_done,
    input  logic empty_flag,
    input  logic done_flag,
    output logic irq
);
    logic empty_prev;
    logic done_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_prev <= 1'b1;
            done_prev  <= 1'b1;
        end else begin
            empty_prev <= empty_flag;
            done_prev  <= done_flag;
        end
    end

    assign irq = sel_done ? (done_flag && !done_prev)
                          : (empty_flag && !empty_prev);

endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              char8,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    input  logic              irq_sel,
    input  logic              brg_div4,
    input  logic [DIV_W-1:0]  brg_n,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_done,
    output logic              irq
);
    tx_fmt_t           fmt;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              run;
    logic              bit_tick;

    assign fmt.char8   = char8;
    assign fmt.par_en  = par_en;
    assign fmt.par_odd = par_odd;
    assign fmt.stop2   = stop2;
    assign buf_empty   = !hold_full;

    uart_tx_baud #(.DIV_W(DIV_W), .PRESCALE(4), .OVERSAMPLE(16)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div4     (brg_div4),
        .div_n    (brg_n),
        .bit_tick (bit_tick)
    );

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .fmt        (fmt),
        .take       (take),
        .run        (run),
        .txd        (txd),
        .shift_done (shift_done)
    );

    uart_tx_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_done   (irq_sel),
        .empty_flag (buf_empty),
        .done_flag  (shift_done),
        .irq        (irq)
    );

endmodule

// File: rtl/uart_dbuf_tx_chk.sv
module uart_dbuf_tx_chk #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_sel,
    input logic [DIV_W-1:0]  brg_n,
    input logic              txd,
    input logic              buf_empty,
    input logic              shift_done,
    input logic              irq
);
    p_wr_clears_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !buf_empty);

    p_empty_rise_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> !shift_done);

    p_done_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_done |-> txd);

    p_frame_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_done) |-> !txd);

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_sel ? shift_done : buf_empty));

    p_known_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({txd, buf_empty, shift_done, irq}));

endmodule

bind uart_dbuf_tx uart_dbuf_tx_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .irq_sel    (irq_sel),
    .brg_n      (brg_n),
    .txd        (txd),
    .buf_empty  (buf_empty),
    .shift_done (shift_done),
    .irq        (irq)
);

// File: tb/uart_dbuf_tx_tb.sv
`timescale 1ns/1ps
module uart_dbuf_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       char8 = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stop2 = 1'b0;
    logic       irq_sel = 1'b0;
    logic       brg_div4 = 1'b0;
    logic [7:0] brg_n = '0;
    logic       txd, buf_empty, shift_done, irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    uart_dbuf_tx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .char8      (char8),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .stop2      (stop2),
        .irq_sel    (irq_sel),
        .brg_div4   (brg_div4),
        .brg_n      (brg_n),
        .txd        (txd),
        .buf_empty  (buf_empty),
        .shift_done (shift_done),
        .irq        (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Writes one character; returns at the negedge just before the transfer edge.
    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Entered one negedge before the frame's first edge, leaves on its last negedge.
    task automatic expect_frame(input logic [7:0] d, input int P,
                                input logic exp_empty0, input logic exp_irq0);
        logic [11:0] bits;
        int nb;
        int par_pos;
        logic par;
        bits    = '1;
        bits[0] = 1'b0;
        nb      = 1;
        for (int i = 0; i < (char8 ? 8 : 7); i++) begin
            bits[nb] = d[i];
            nb++;
        end
        par     = (^(char8 ? d : {1'b0, d[6:0]})) ^ par_odd;
        par_pos = -1;
        if (par_en) begin
            bits[nb] = par;
            par_pos  = nb;
            nb++;
        end
        nb += stop2 ? 2 : 1;
        for (int j = 0; j < P * nb; j++) begin
            @(negedge clk);
            if (j == 0) begin
                wr_en = 1'b0;
                chk("R3 start bit low", txd, 0);
                chk("R6 shift_done low at load", shift_done, 0);
                chk("R5 buf_empty after transfer", buf_empty, exp_empty0);
                chk("R9 irq at transfer", irq, exp_irq0);
            end
            if (j == 1) chk("R9 irq single pulse", irq, 0);
            if (j == P - 1) chk("R2 start still low at bit end", txd, 0);
            if (j == P) chk("R2 first data bit on time", txd, bits[1]);
            if ((j % P) == P / 2) begin
                if ((j / P) == par_pos) chk("R4 parity bit", txd, bits[j / P]);
                else chk("R3 frame bit", txd, bits[j / P]);
            end
        end
    endtask

    // Called at the last negedge of a frame with nothing waiting.
    task automatic end_check();
        chk("R6 shift_done low in last stop", shift_done, 0);
        chk("R3 stop bit high", txd, 1);
        @(negedge clk);
        chk("R6 shift_done after last stop", shift_done, 1);
        chk("R3 idle line high", txd, 1);
        chk("R9 irq on shift done", irq, irq_sel);
        @(negedge clk);
        chk("R9 irq single pulse", irq, 0);
    endtask

    task automatic t_reset();
        chk("R1 txd", txd, 1);
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 shift_done", shift_done, 1);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_basic_8n1();
        char8 = 1; par_en = 0; stop2 = 0; irq_sel = 0; brg_div4 = 0; brg_n = 0;
        write_byte(8'hA5);
        chk("R5 buf_empty clears on write", buf_empty, 0);
        chk("R1 line idle before start", txd, 1);
        expect_frame(8'hA5, 16, 1, 1);
        end_check();
    endtask

    task automatic t_seven_odd_two_stop();
        char8 = 0; par_en = 1; par_odd = 1; stop2 = 1; irq_sel = 1; brg_n = 1;
        write_byte(8'hDB);
        expect_frame(8'hDB, 32, 1, 0);
        end_check();
    endtask

    task automatic t_eight_even();
        char8 = 1; par_en = 1; par_odd = 0; stop2 = 0; irq_sel = 1; brg_n = 0;
        write_byte(8'h37);
        expect_frame(8'h37, 16, 1, 0);
        end_check();
    endtask

    task automatic t_prescaled_rate();
        char8 = 1; par_en = 0; stop2 = 0; irq_sel = 0; brg_div4 = 1; brg_n = 1;
        write_byte(8'h01);
        expect_frame(8'h01, 128, 1, 1);
        end_check();
        brg_div4 = 0;
    endtask

    // Write lands on the transfer edge, then frames run back to back.
    task automatic t_collision_b2b();
        char8 = 1; par_en = 1; par_odd = 1; stop2 = 0; irq_sel = 0; brg_n = 0;
        write_byte(8'h3C);
        wr_en   = 1'b1;
        wr_data = 8'hC6;
        // R8: old character first, buffer stays full, no irq
        expect_frame(8'h3C, 16, 0, 0);
        // R7: next frame starts with no idle gap
        expect_frame(8'hC6, 16, 1, 1);
        end_check();
    endtask

    // Refill lands on the edge that ends a stop bit (R8 during shifting).
    task automatic t_refill_at_stop();
        char8 = 1; par_en = 0; stop2 = 1; irq_sel = 1; brg_n = 0;
        write_byte(8'h81);
        wr_en   = 1'b1;
        wr_data = 8'h7E;
        expect_frame(8'h81, 16, 0, 0);
        wr_en   = 1'b1;
        wr_data = 8'h55;
        expect_frame(8'h7E, 16, 0, 0);
        expect_frame(8'h55, 16, 1, 0);
        end_check();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_8n1();
        t_seven_odd_two_stop();
        t_eight_even();
        t_prescaled_rate();
        t_collision_b2b();
        t_refill_at_stop();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule